// File: doc/BRIEF.md
# Debug Event Control Unit

This unit sits beside an in-order instruction pipeline. It sees one instruction per clock and decides what happens when a debug event fires. Two event kinds are handled: a taken branch and a satisfied trap condition. Each kind has its own enable bit. Four independent mode inputs (external halt, debug wait, internal, trace) and the machine-state debug-interrupt enable decide what an event does. It can stop the core and capture the PC, raise a precise debug interrupt, raise a trap program interrupt and record the debug event as imprecise, only log the event and pulse the trace output, or do nothing at all.

The instruction port is a valid/ready stream. `instr_ready` is low while the core is stopped, and any instruction offered during that time is dropped rather than held. The pipeline must keep offering it until `instr_ready` returns after a `resume` pulse. `suppress` is combinational and applies in the same cycle as `instr_valid`. All other outputs are registered and change one clock after the instruction. Status bits are cleared by software with a write-one-to-clear mask.

Top module: `dbg_event_ctl`

## Requirements
- R1: A branch event fires only for an accepted instruction with `instr_br_taken`=1 and `ctl_brt_en`=1. A trap event fires only for an accepted instruction with `instr_trap_met`=1 and `ctl_trap_en`=1. An instruction is accepted when `instr_valid`=1 and `instr_ready`=1.
- R2: In halt handling (`mode_ext` or `mode_wait` is 1), an event does four things. It sets its status bit, asserts `suppress` in the same cycle, sets `stopped` on the next clock, and loads `stop_pc` with `instr_addr`.
- R3: In internal mode with `msr_de`=1, an event sets its status bit and asserts `suppress`. On the next clock it pulses `dbg_irq` and loads `dbg_ret_addr` with `instr_addr`.
- R4: In internal mode with `msr_de`=0, a branch event has no effect: no status change, no suppress, no pulse.
- R5: In internal mode with `msr_de`=0, a trap event sets the trap bit and the imprecise bit, asserts `suppress`, and pulses `prog_irq`. `dbg_irq` and `prog_irq` are never high together.
- R6: In internal mode, a rise of `msr_de` from 0 to 1 while the trap status bit is set pulses `dbg_irq` on the next clock, and the imprecise bit stays set. If the trap bit was cleared before the rise, there is no pulse.
- R7: In trace handling, an event sets its status bit and pulses `trace_pulse` on the next clock. `suppress` stays 0.
- R8: Mode priority is halt first, then internal, then trace. When no mode input is 1, events have no effect.
- R9: `dbg_status` bit 0 records branch events, bit 1 records trap events and bit 2 records an imprecise event. When `sts_clr_valid`=1, each bit set in `sts_clr_mask` clears the matching status bit. A new event setting a bit in the same cycle wins over the clear.
- R10: `stopped` holds until `resume` pulses. While stopped, `instr_ready`=0, and offered instructions cause no suppress, no status change and no change to `stop_pc`.
- R11: `dbg_irq`, `prog_irq` and `trace_pulse` are one-cycle pulses per event.
- R12: After reset, status is 0, `stopped`=0, `instr_ready`=1 and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr_ready | output | 1 | Instruction accepted (low while stopped) |
| instr_addr | input | ADDR_W | Address of the offered instruction |
| instr_br_taken | input | 1 | Branch condition met, stream redirects |
| instr_trap_met | input | 1 | Trap condition met |
| ctl_brt_en | input | 1 | Branch event enable |
| ctl_trap_en | input | 1 | Trap event enable |
| mode_ext | input | 1 | External debug mode |
| mode_wait | input | 1 | Debug wait mode |
| mode_int | input | 1 | Internal debug mode |
| mode_trace | input | 1 | Trace mode |
| msr_de | input | 1 | Debug interrupt enable |
| sts_clr_valid | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-one-to-clear mask |
| resume | input | 1 | Leave the stop state |
| dbg_status | output | 3 | {imprecise, trap, branch} |
| suppress | output | 1 | Suppress the current instruction (combinational) |
| stopped | output | 1 | Core in stop state |
| stop_pc | output | ADDR_W | Captured PC at stop |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| dbg_ret_addr | output | ADDR_W | Saved return address |
| prog_irq | output | 1 | Trap program interrupt pulse |
| trace_pulse | output | 1 | Trace event pulse |

## Verification
The bench first checks that branch events are dropped entirely in internal mode with interrupts masked. A design that handled them like traps would set bits and raise a program interrupt there. It then checks the delayed interrupt two ways: it must fire on the enable rise while the trap bit is set, and it must not fire once the bit has been cleared. It also checks that overlapping mode inputs resolve with halt first, internal next and trace last, so that trace-only handling never suppresses. Finally it checks that a status clear never beats a new event in the same cycle, and that instructions offered while stopped leave the captured PC and the status untouched.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
  localparam int ST_W    = 3;
  localparam int BIT_BRT = 0;
  localparam int BIT_TRP = 1;
  localparam int BIT_IMP = 2;

  typedef enum logic [2:0] {
    RES_NONE,
    RES_HALT,
    RES_INTR,
    RES_MASKED,
    RES_TRACE
  } resolve_e;

  typedef struct packed {
    logic            suppress;
    logic            stop;
    logic            dbg_irq;
    logic            prog_irq;
    logic            trace;
    logic [ST_W-1:0] set;
  } action_t;
endpackage

// File: rtl/dbg_mode_resolve.sv
module dbg_mode_resolve
  import dbg_event_pkg::*;
(
  input  logic     mode_ext_i,
  input  logic     mode_wait_i,
  input  logic     mode_int_i,
  input  logic     mode_trace_i,
  input  logic     de_i,
  output resolve_e res_o
);
  // Halt modes first, then internal, trace only when the others are idle.
  always_comb begin
    if (mode_ext_i || mode_wait_i) res_o = RES_HALT;
    else if (mode_int_i)           res_o = de_i ? RES_INTR : RES_MASKED;
    else if (mode_trace_i)         res_o = RES_TRACE;
    else                           res_o = RES_NONE;
  end
endmodule

// File: rtl/dbg_event_decide.sv
module dbg_event_decide
  import dbg_event_pkg::*;
(
  input  logic     accept_i,
  input  logic     brt_hit_i,
  input  logic     trp_hit_i,
  input  resolve_e res_i,
  output action_t  act_o
);
  logic brt_ev, trp_ev, any_ev;
  logic [ST_W-1:0] plain_set;

  assign brt_ev = accept_i && brt_hit_i;
  assign trp_ev = accept_i && trp_hit_i;
  assign any_ev = brt_ev || trp_ev;

  always_comb begin
    plain_set          = '0;
    plain_set[BIT_BRT] = brt_ev;
    plain_set[BIT_TRP] = trp_ev;
  end

  always_comb begin
    act_o = '0;
    unique case (res_i)
      RES_HALT: begin
        act_o.suppress = any_ev;
        act_o.stop     = any_ev;
        act_o.set      = plain_set;
      end
      RES_INTR: begin
        act_o.suppress = any_ev;
        act_o.dbg_irq  = any_ev;
        act_o.set      = plain_set;
      end
      RES_MASKED: begin
        // Branch events vanish here; traps go imprecise.
        act_o.suppress     = trp_ev;
        act_o.prog_irq     = trp_ev;
        act_o.set[BIT_TRP] = trp_ev;
        act_o.set[BIT_IMP] = trp_ev;
      end
      RES_TRACE: begin
        act_o.trace = any_ev;
        act_o.set   = plain_set;
      end
      default: act_o = '0;
    endcase
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_event_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_i,
  input  logic            clr_valid_i,
  input  logic [ST_W-1:0] clr_mask_i,
  output logic [ST_W-1:0] status_o
);
  for (genvar k = 0; k < ST_W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                            status_o[k] <= 1'b0;
      else if (set_i[k])                     status_o[k] <= 1'b1;
      else if (clr_valid_i && clr_mask_i[k]) status_o[k] <= 1'b0;
    end
  end

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dbg_stop_ctl.sv
module dbg_stop_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              resume_i,
  output logic              stopped_o,
  output logic [ADDR_W-1:0] stop_pc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stopped_o <= 1'b0;
      stop_pc_o <= '0;
    end else if (stop_i) begin
      stopped_o <= 1'b1;
      stop_pc_o <= addr_i;
    end else if (resume_i) begin
      stopped_o <= 1'b0;
    end
  end

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && !resume_i) |=> (stopped_o && $stable(stop_pc_o)));
endmodule

// File: rtl/dbg_irq_gen.sv
module dbg_irq_gen
  import dbg_event_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  action_t           act_i,
  input  resolve_e          res_i,
  input  logic              de_i,
  input  logic              trap_pending_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              dbg_irq_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              prog_irq_o,
  output logic              trace_o
);
  logic de_q;
  logic late_irq;

  // Delayed interrupt: enable rises in internal mode with a trap still logged.
  assign late_irq = (res_i == RES_INTR) && !de_q && trap_pending_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q       <= 1'b0;
      dbg_irq_o  <= 1'b0;
      prog_irq_o <= 1'b0;
      trace_o    <= 1'b0;
      ret_addr_o <= '0;
    end else begin
      de_q       <= de_i;
      dbg_irq_o  <= act_i.dbg_irq || late_irq;
      prog_irq_o <= act_i.prog_irq;
      trace_o    <= act_i.trace;
      if (act_i.dbg_irq) ret_addr_o <= addr_i;
    end
  end

  // R5
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_irq_o && prog_irq_o));
endmodule

// File: rtl/dbg_event_ctl.sv
module dbg_event_ctl
  import dbg_event_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              instr_br_taken,
  input  logic              instr_trap_met,
  input  logic              ctl_brt_en,
  input  logic              ctl_trap_en,
  input  logic              mode_ext,
  input  logic              mode_wait,
  input  logic              mode_int,
  input  logic              mode_trace,
  input  logic              msr_de,
  input  logic              sts_clr_valid,
  input  logic [ST_W-1:0]   sts_clr_mask,
  input  logic              resume,
  output logic [ST_W-1:0]   dbg_status,
  output logic              suppress,
  output logic              stopped,
  output logic [ADDR_W-1:0] stop_pc,
  output logic              dbg_irq,
  output logic [ADDR_W-1:0] dbg_ret_addr,
  output logic              prog_irq,
  output logic              trace_pulse
);
  resolve_e res;
  action_t  act;
  logic     accept;

  assign instr_ready = !stopped;
  assign accept      = instr_valid && instr_ready;
  assign suppress    = act.suppress;

  dbg_mode_resolve u_resolve (
    .mode_ext_i   (mode_ext),
    .mode_wait_i  (mode_wait),
    .mode_int_i   (mode_int),
    .mode_trace_i (mode_trace),
    .de_i         (msr_de),
    .res_o        (res)
  );

  dbg_event_decide u_decide (
    .accept_i  (accept),
    .brt_hit_i (instr_br_taken && ctl_brt_en),
    .trp_hit_i (instr_trap_met && ctl_trap_en),
    .res_i     (res),
    .act_o     (act)
  );

  dbg_status_reg u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (act.set),
    .clr_valid_i (sts_clr_valid),
    .clr_mask_i  (sts_clr_mask),
    .status_o    (dbg_status)
  );

  dbg_stop_ctl #(.ADDR_W(ADDR_W)) u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (act.stop),
    .addr_i    (instr_addr),
    .resume_i  (resume),
    .stopped_o (stopped),
    .stop_pc_o (stop_pc)
  );

  dbg_irq_gen #(.ADDR_W(ADDR_W)) u_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .act_i          (act),
    .res_i          (res),
    .de_i           (msr_de),
    .trap_pending_i (dbg_status[BIT_TRP]),
    .addr_i         (instr_addr),
    .dbg_irq_o      (dbg_irq),
    .ret_addr_o     (dbg_ret_addr),
    .prog_irq_o     (prog_irq),
    .trace_o        (trace_pulse)
  );

  // R7
  trace_no_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_trace && !mode_ext && !mode_wait && !mode_int) |-> !suppress);

  // R10
  stopped_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!suppress && !instr_ready));
endmodule

// File: tb/tb_dbg_event_ctl.sv
`timescale 1ns/1ps
module tb_dbg_event_ctl;
  localparam int AW = 32;
  logic clk = 1'b0;
  logic rst_n;
  logic instr_valid, instr_ready, br, tr, enb, ent;
  logic ext, wt, intm, trc, de, clr_v, resume;
  logic [AW-1:0] addr;
  logic [2:0] clr_m, status;
  logic sup, stp, dirq, pirq, tpul;
  logic [AW-1:0] spc, rad;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dbg_event_ctl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_addr(addr), .instr_br_taken(br), .instr_trap_met(tr),
    .ctl_brt_en(enb), .ctl_trap_en(ent), .mode_ext(ext), .mode_wait(wt),
    .mode_int(intm), .mode_trace(trc), .msr_de(de), .sts_clr_valid(clr_v),
    .sts_clr_mask(clr_m), .resume(resume), .dbg_status(status), .suppress(sup),
    .stopped(stp), .stop_pc(spc), .dbg_irq(dirq), .dbg_ret_addr(rad),
    .prog_irq(pirq), .trace_pulse(tpul)
  );

  // [16:13] ext,wait,int,trace [12] de [11:8] brt_en,trap_en,br,trap
  // [7:3] exp suppress,stopped,dbg_irq,prog_irq,trace [2:0] exp status
  localparam logic [16:0] VEC [14] = '{
    17'b1000_0_1010_11000_001,
    17'b0100_0_0101_11000_010,
    17'b0010_1_1010_10100_001,
    17'b0010_1_0101_10100_010,
    17'b0010_0_1010_00000_000,
    17'b0010_0_0101_10010_110,
    17'b0001_0_1010_00001_001,
    17'b0001_0_0101_00001_010,
    17'b1010_0_1010_11000_001,
    17'b0011_1_0101_10100_010,
    17'b0010_1_0010_00000_000,
    17'b0000_0_1111_00000_000,
    17'b0011_0_1010_00000_000,
    17'b0011_1_1111_10100_011
  };

  function automatic string vtag(int i);
    case (i)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6, 7: return "R7";
      10: return "R1";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    instr_valid = 0; br = 0; tr = 0; clr_v = 0; clr_m = 0; resume = 0;
  endtask

  task automatic offer(logic b, logic t, logic [AW-1:0] a);
    instr_valid = 1; br = b; tr = t; addr = a;
  endtask

  task automatic set_mode(logic e, logic w, logic i, logic c);
    ext = e; wt = w; intm = i; trc = c;
  endtask

  task automatic clean();
    idle(); clr_v = 1; clr_m = 3'b111; resume = 1;
    @(negedge clk); idle(); @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); addr = 0; enb = 0; ent = 0; de = 0; set_mode(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12", "status", AW'(status), 0);
    check("R12", "stopped", AW'(stp), 0);
    check("R12", "ready", AW'(instr_ready), 1);
    check("R12", "pulses", AW'({dirq, pirq, tpul}), 0);

    for (int i = 0; i < 14; i++) begin
      logic [16:0] v;
      logic [AW-1:0] a;
      v = VEC[i];
      a = AW'(32'h1000 + i * 4);
      set_mode(v[16], v[15], v[14], v[13]); de = v[12];
      enb = v[11]; ent = v[10];
      offer(v[9], v[8], a);
      #1 check(vtag(i), "suppress", AW'(sup), AW'(v[7]));
      @(negedge clk);
      idle();
      check(vtag(i), "stopped", AW'(stp), AW'(v[6]));
      check(vtag(i), "dbg_irq", AW'(dirq), AW'(v[5]));
      check(vtag(i), "prog_irq", AW'(pirq), AW'(v[4]));
      check(vtag(i), "trace", AW'(tpul), AW'(v[3]));
      check(vtag(i), "status", AW'(status), AW'(v[2:0]));
      if (v[6]) check(vtag(i), "stop_pc", spc, a);
      if (v[5]) check(vtag(i), "ret_addr", rad, a);
      clean();
    end

    // R11 pulse lasts one cycle
    enb = 1; ent = 1; set_mode(0, 0, 1, 0); de = 1;
    offer(0, 1, 32'h2000);
    @(negedge clk); idle();
    check("R11", "dbg_irq first", AW'(dirq), 1);
    @(negedge clk);
    check("R11", "dbg_irq second", AW'(dirq), 0);
    clean();

    // R6 delayed interrupt on enable rise
    de = 0; offer(0, 1, 32'h2100);
    @(negedge clk); idle();
    check("R5", "prog_irq", AW'(pirq), 1);
    @(negedge clk);
    de = 1;
    @(negedge clk);
    check("R6", "delayed dbg_irq", AW'(dirq), 1);
    check("R6", "imprecise kept", AW'(status), 3'b110);
    @(negedge clk);
    check("R11", "delayed pulse ends", AW'(dirq), 0);
    clean();

    // R6 no delayed interrupt once trap cleared
    de = 0; offer(0, 1, 32'h2200);
    @(negedge clk); idle();
    clean();
    de = 1;
    @(negedge clk);
    check("R6", "no delayed irq", AW'(dirq), 0);
    de = 0; clean();

    // R9 event beats clear, partial masks
    set_mode(0, 0, 0, 1);
    offer(0, 1, 32'h2300);
    @(negedge clk); idle();
    offer(0, 1, 32'h2304); clr_v = 1; clr_m = 3'b111;
    @(negedge clk); idle();
    check("R9", "event wins", AW'(status), 3'b010);
    offer(1, 0, 32'h2308); clr_v = 1; clr_m = 3'b001;
    @(negedge clk); idle();
    check("R9", "branch wins", AW'(status), 3'b011);
    clr_v = 1; clr_m = 3'b010;
    @(negedge clk); idle();
    check("R9", "partial clear", AW'(status), 3'b001);
    clean();

    // R10 stop holds, strobes ignored, resume
    set_mode(1, 0, 0, 0);
    offer(1, 0, 32'h3000);
    @(negedge clk); idle();
    check("R10", "stopped", AW'(stp), 1);
    check("R10", "ready low", AW'(instr_ready), 0);
    offer(0, 1, 32'h3004);
    #1 check("R10", "no suppress while stopped", AW'(sup), 0);
    @(negedge clk); idle();
    check("R10", "pc kept", spc, 32'h3000);
    check("R10", "status unchanged", AW'(status), 3'b001);
    check("R10", "still stopped", AW'(stp), 1);
    resume = 1;
    @(negedge clk); idle();
    check("R10", "resumed", AW'(stp), 0);
    check("R10", "ready back", AW'(instr_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule